// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

The block collects interrupt requests from external sources and from interprocessor messages. It routes each request to one or more processors and drives one interrupt line per processor. Each source has a configuration word that sets its priority, vector, input polarity, edge or level detection and mask. A separate word holds the set of processors the source is routed to. Each processor has a task priority threshold, an acknowledge register that returns the vector being delivered, an end-of-interrupt register and dispatch registers for interprocessor interrupts.

Software reaches all registers through a simple 32-bit register bus. Reads are combinational within the cycle in which `bus_re` is high, and any side effect of a read takes place on the clock edge that ends that cycle. Writes take effect on the clock edge of the cycle in which `bus_we` is high. Addresses are word indices: 0x00 features, 0x01 global control, 0x02 spurious vector, 0x10+s source configuration, 0x20+s source routing, 0x30+i interprocessor configuration. Processor c has its window at 0x40+8c: +0 task priority, +1 acknowledge, +2 end of interrupt, +4+i dispatch of interprocessor interrupt i.

Top module: `mp_intc`

## Requirements
- R1: After reset every source and interprocessor mask bit is 1, every priority, vector, routing mask and task priority is 0, source polarity reads 1 and sense reads 0, and every `cpu_int` bit is 0; an idle source configuration word reads 0x80400000 and an idle interprocessor word reads 0x80000000.
- R2: A configuration word has the mask in bit 31, activity in bit 30 (read-only), sense in bit 23, polarity in bit 22, priority in bits 19:16 and vector in bits 7:0. A written mask value reads back on the next access, and a masked request is never delivered, although its edge is still latched.
- R3: A source with sense 0 latches a pending flag on the rising edge of its input after polarity correction, holds it after the input returns inactive, and the flag clears when a processor acknowledges it.
- R4: A source with sense 1 is pending exactly while its input is active, where polarity 1 means active-high and polarity 0 means active-low.
- R5: A source is delivered to every processor whose bit is set in its routing word; acknowledgement on one processor does not remove a level request from another.
- R6: A processor's line is asserted only when the best candidate priority is strictly greater than its task priority (bits 3:0 of its +0 register); 15 blocks every request and 0 admits any priority from 1 up.
- R7: Among deliverable requests the highest priority wins, ties going to the lowest index, with sources 0..15 ranked ahead of interprocessor interrupts 0..3.
- R8: An acknowledge read on a processor whose line is asserted returns the winner's vector and places it in service. A further request reaches that processor only if its priority is strictly above every priority it has in service.
- R9: Any write to a processor's end-of-interrupt register retires the highest-priority interrupt that processor has in service.
- R10: An acknowledge read on a processor whose line is low returns the spurious vector (register 0x02, bits 7:0).
- R11: The activity bit of a source or interprocessor interrupt reads 1 while it is pending on any processor or in service on any processor, and 0 otherwise.
- R12: Writing a processor mask to any processor's dispatch register for interprocessor interrupt i makes that interrupt pending on every processor named in the mask.
- R13: Writing 1 to bit 0 of the global control register returns all state to the R1 values on that edge, and the bit reads 0. Bit 1 holds the legacy pass-through disable flag and reads back as written.
- R14: The feature register reads the version code in bits 3:0, the last processor index in bits 12:8 and the last source index in bits 26:16 (0x000F0103 with the default sizes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NSRC | External source inputs |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_re` |
| cpu_int | output | NCPU | Interrupt line per processor |

## Verification
The hardest case to reach from the ports is nested delivery. Here an end-of-interrupt must retire the higher of two in-service interrupts while a third request of equal priority to the lower one waits and must stay blocked until the second retirement. The stimulus builds this from three edge sources, two sharing priority 5 and one at 9. It raises them in turn and interleaves acknowledge reads with line checks. It then reads the activity bits to show which interrupt each end-of-interrupt removed.

// File: rtl/mp_intc.sv
module mp_intc #(
  parameter int NCPU = 2,
  parameter int NSRC = 16,
  parameter int NIPI = 4,
  parameter int VW   = 8,
  parameter int AW   = 8,
  parameter int VER  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCPU-1:0] cpu_int
);
  localparam int NREQ   = NSRC + NIPI;
  localparam int RW     = $clog2(NREQ);
  localparam int A_FEAT = 'h00;
  localparam int A_GCFG = 'h01;
  localparam int A_SPUR = 'h02;
  localparam int A_SRC  = 'h10;
  localparam int A_DST  = 'h20;
  localparam int A_IPI  = 'h30;
  localparam int A_CPU  = 'h40;
  localparam int STRIDE = 8;

  logic [NSRC-1:0] s_mask, s_pol, s_sense, e_pend, act_q;
  logic [3:0]      s_pri [NSRC];
  logic [VW-1:0]   s_vec [NSRC];
  logic [NCPU-1:0] s_dst [NSRC];
  logic [NIPI-1:0] i_mask;
  logic [3:0]      i_pri [NIPI];
  logic [VW-1:0]   i_vec [NIPI];
  logic [NIPI-1:0] i_pend [NCPU];
  logic [3:0]      tpr [NCPU];
  logic [NREQ-1:0] isr [NCPU];
  logic [VW-1:0]   spur;
  logic            pt_dis;

  logic [NSRC-1:0] act, s_pend, s_act, src_clr;
  logic [NIPI-1:0] i_act;
  logic [3:0]      r_pri [NREQ];
  logic [VW-1:0]   r_vec [NREQ];
  logic [NREQ-1:0] r_msk;
  logic [NSRC-1:0] dcol [NCPU];
  logic [NREQ-1:0] cand [NCPU];
  logic [NCPU-1:0] has, has_isr, ack_rd, eoi_wr, tpr_wr;
  logic [3:0]      best_pri [NCPU];
  logic [3:0]      cur_pri [NCPU];
  logic [RW-1:0]   best_idx [NCPU];
  logic [RW-1:0]   top_isr [NCPU];
  logic [NIPI-1:0] disp_wr [NCPU];
  logic [NIPI-1:0] ipi_set [NCPU];
  logic [NREQ-1:0] isr_set [NCPU];
  logic [NREQ-1:0] eoi_clr [NCPU];
  logic [31:0]     feat;
  logic            soft_rst;
  logic            unused_wbits;

  assign act      = ~(irq_in ^ s_pol);
  assign s_pend   = (s_sense & act) | (~s_sense & e_pend);
  assign soft_rst = bus_we && bus_addr == AW'(A_GCFG) && bus_wdata[0];
  assign feat     = {5'b0, 11'(NSRC-1), 3'b0, 5'(NCPU-1), 4'b0, 4'(VER)};
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      r_pri[s] = s_pri[s];
      r_vec[s] = s_vec[s];
      r_msk[s] = s_mask[s];
    end
    for (int i = 0; i < NIPI; i++) begin
      r_pri[NSRC+i] = i_pri[i];
      r_vec[NSRC+i] = i_vec[i];
      r_msk[NSRC+i] = i_mask[i];
    end
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      for (int s = 0; s < NSRC; s++) dcol[c][s] = s_dst[s][c];
      cand[c]     = {i_pend[c], s_pend & dcol[c]} & ~r_msk & ~isr[c];
      has[c]      = 1'b0;
      best_pri[c] = '0;
      best_idx[c] = '0;
      has_isr[c]  = 1'b0;
      cur_pri[c]  = '0;
      top_isr[c]  = '0;
      for (int r = 0; r < NREQ; r++) begin
        if (cand[c][r] && (!has[c] || r_pri[r] > best_pri[c])) begin
          has[c]      = 1'b1;
          best_pri[c] = r_pri[r];
          best_idx[c] = RW'(r);
        end
        if (isr[c][r] && (!has_isr[c] || r_pri[r] > cur_pri[c])) begin
          has_isr[c] = 1'b1;
          cur_pri[c] = r_pri[r];
          top_isr[c] = RW'(r);
        end
      end
      cpu_int[c] = has[c] && best_pri[c] > tpr[c] && best_pri[c] > cur_pri[c];
    end
  end

  always_comb begin
    src_clr = '0;
    s_act   = s_pend;
    i_act   = '0;
    for (int c = 0; c < NCPU; c++) begin
      tpr_wr[c]  = bus_we && bus_addr == AW'(A_CPU + c*STRIDE);
      ack_rd[c]  = bus_re && bus_addr == AW'(A_CPU + c*STRIDE + 1);
      eoi_wr[c]  = bus_we && bus_addr == AW'(A_CPU + c*STRIDE + 2);
      for (int i = 0; i < NIPI; i++)
        disp_wr[c][i] = bus_we && bus_addr == AW'(A_CPU + c*STRIDE + 4 + i);
      isr_set[c] = (ack_rd[c] && cpu_int[c]) ? (NREQ'(1) << best_idx[c]) : '0;
      eoi_clr[c] = (eoi_wr[c] && has_isr[c]) ? (NREQ'(1) << top_isr[c]) : '0;
      src_clr    = src_clr | isr_set[c][NSRC-1:0];
      s_act      = s_act | isr[c][NSRC-1:0];
      i_act      = i_act | i_pend[c] | isr[c][NREQ-1:NSRC];
    end
    for (int k = 0; k < NCPU; k++) begin
      ipi_set[k] = '0;
      for (int c = 0; c < NCPU; c++)
        ipi_set[k] = ipi_set[k] | (disp_wr[c] & {NIPI{bus_wdata[k]}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      s_mask  <= '1;
      s_pol   <= '1;
      s_sense <= '0;
      e_pend  <= '0;
      act_q   <= '0;
      i_mask  <= '1;
      spur    <= '0;
      pt_dis  <= 1'b0;
      for (int s = 0; s < NSRC; s++) begin
        s_pri[s] <= '0;
        s_vec[s] <= '0;
        s_dst[s] <= '0;
      end
      for (int i = 0; i < NIPI; i++) begin
        i_pri[i] <= '0;
        i_vec[i] <= '0;
      end
      for (int c = 0; c < NCPU; c++) begin
        i_pend[c] <= '0;
        tpr[c]    <= '0;
        isr[c]    <= '0;
      end
    end else begin
      act_q  <= act;
      e_pend <= (e_pend & ~src_clr) | (act & ~act_q & ~s_sense);
      for (int c = 0; c < NCPU; c++) begin
        i_pend[c] <= (i_pend[c] & ~isr_set[c][NREQ-1:NSRC]) | ipi_set[c];
        isr[c]    <= (isr[c] & ~eoi_clr[c]) | isr_set[c];
        if (tpr_wr[c]) tpr[c] <= bus_wdata[3:0];
      end
      if (bus_we) begin
        if (bus_addr == AW'(A_GCFG)) pt_dis <= bus_wdata[1];
        if (bus_addr == AW'(A_SPUR)) spur <= bus_wdata[VW-1:0];
        for (int s = 0; s < NSRC; s++) begin
          if (bus_addr == AW'(A_SRC + s)) begin
            s_mask[s]  <= bus_wdata[31];
            s_sense[s] <= bus_wdata[23];
            s_pol[s]   <= bus_wdata[22];
            s_pri[s]   <= bus_wdata[19:16];
            s_vec[s]   <= bus_wdata[VW-1:0];
          end
          if (bus_addr == AW'(A_DST + s)) s_dst[s] <= bus_wdata[NCPU-1:0];
        end
        for (int i = 0; i < NIPI; i++) begin
          if (bus_addr == AW'(A_IPI + i)) begin
            i_mask[i] <= bus_wdata[31];
            i_pri[i]  <= bus_wdata[19:16];
            i_vec[i]  <= bus_wdata[VW-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_FEAT)) bus_rdata = feat;
    if (bus_addr == AW'(A_GCFG)) bus_rdata = {30'b0, pt_dis, 1'b0};
    if (bus_addr == AW'(A_SPUR)) bus_rdata = 32'(spur);
    for (int s = 0; s < NSRC; s++) begin
      if (bus_addr == AW'(A_SRC + s))
        bus_rdata = {s_mask[s], s_act[s], 6'b0, s_sense[s], s_pol[s], 2'b0,
                     s_pri[s], 16'(s_vec[s])};
      if (bus_addr == AW'(A_DST + s)) bus_rdata = 32'(s_dst[s]);
    end
    for (int i = 0; i < NIPI; i++)
      if (bus_addr == AW'(A_IPI + i))
        bus_rdata = {i_mask[i], i_act[i], 10'b0, i_pri[i], 16'(i_vec[i])};
    for (int c = 0; c < NCPU; c++) begin
      if (bus_addr == AW'(A_CPU + c*STRIDE)) bus_rdata = 32'(tpr[c]);
      if (ack_rd[c] || bus_addr == AW'(A_CPU + c*STRIDE + 1))
        bus_rdata = cpu_int[c] ? 32'(r_vec[best_idx[c]]) : 32'(spur);
    end
  end

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_chk
      p_tpr_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tpr[c] == 4'hF |-> !cpu_int[c]);
      p_ack_enters_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd[c] && cpu_int[c]) |=> $countones(isr[c]) == $past($countones(isr[c])) + 1);
      p_eoi_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr[c] && |isr[c]) |=> $countones(isr[c]) == $past($countones(isr[c])) - 1);
    end
    for (genvar s = 0; s < NSRC; s++) begin : g_mchk
      p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(A_SRC + s) && !soft_rst) |=> s_mask[s] == $past(bus_wdata[31]));
    end
  endgenerate

  p_soft_rst_r13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cpu_int == '0) && (s_mask == '1) && (i_mask == '1));
endmodule

// File: tb/mp_intc_tb.sv
`timescale 1ns/1ps
module mp_intc_tb;
  localparam logic [1:0] KW = 2'd0, KR = 2'd1, KI = 2'd2, KC = 2'd3;
  localparam int NV = 78;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  cpu_int;
  int          n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mp_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .cpu_int(cpu_int)
  );

  // {req, kind, addr, data, expected}
  localparam logic [77:0] TBL [NV] = '{
    {4'd14, KR, 8'h00, 32'h0, 32'h000F0103},   // R14 feature word
    {4'd0,  KW, 8'h02, 32'hFF, 32'h0},
    {4'd10, KR, 8'h02, 32'h0, 32'hFF},         // R10
    {4'd10, KR, 8'h41, 32'h0, 32'hFF},         // R10 spurious on idle ack
    {4'd0,  KW, 8'h13, 32'h00450033, 32'h0},
    {4'd0,  KW, 8'h23, 32'h1, 32'h0},
    {4'd2,  KR, 8'h13, 32'h0, 32'h00450033},   // R2 unmask visible
    {4'd3,  KI, 8'h00, 32'h0008, 32'h0},
    {4'd3,  KC, 8'h00, 32'h0, 32'h1},          // R3 edge latched
    {4'd11, KR, 8'h13, 32'h0, 32'h40450033},   // R11 pending
    {4'd3,  KI, 8'h00, 32'h0000, 32'h0},
    {4'd3,  KC, 8'h00, 32'h0, 32'h1},          // R3 held after input drops
    {4'd8,  KR, 8'h41, 32'h0, 32'h33},         // R8 vector
    {4'd8,  KC, 8'h00, 32'h0, 32'h0},          // R8 / R3 cleared
    {4'd11, KR, 8'h13, 32'h0, 32'h40450033},   // R11 in service
    {4'd9,  KW, 8'h42, 32'h0, 32'h0},
    {4'd11, KR, 8'h13, 32'h0, 32'h00450033},   // R11 idle after EOI
    {4'd9,  KC, 8'h00, 32'h0, 32'h0},
    {4'd0,  KW, 8'h15, 32'h00870055, 32'h0},
    {4'd0,  KW, 8'h25, 32'h3, 32'h0},
    {4'd5,  KC, 8'h00, 32'h0, 32'h3},          // R5 both, R4 active-low
    {4'd4,  KR, 8'h49, 32'h0, 32'h55},
    {4'd5,  KC, 8'h00, 32'h0, 32'h1},          // R5 other cpu still sees it
    {4'd5,  KR, 8'h41, 32'h0, 32'h55},
    {4'd5,  KC, 8'h00, 32'h0, 32'h0},
    {4'd4,  KI, 8'h00, 32'h0020, 32'h0},
    {4'd0,  KW, 8'h42, 32'h0, 32'h0},
    {4'd0,  KW, 8'h4A, 32'h0, 32'h0},
    {4'd4,  KR, 8'h15, 32'h0, 32'h00870055},   // R4 inactive level not pending
    {4'd0,  KW, 8'h40, 32'h5, 32'h0},
    {4'd6,  KI, 8'h00, 32'h0028, 32'h0},
    {4'd6,  KC, 8'h00, 32'h0, 32'h0},          // R6 equal blocked
    {4'd0,  KW, 8'h40, 32'h4, 32'h0},
    {4'd6,  KC, 8'h00, 32'h0, 32'h1},          // R6
    {4'd0,  KW, 8'h40, 32'hF, 32'h0},
    {4'd6,  KC, 8'h00, 32'h0, 32'h0},          // R6 15 blocks
    {4'd6,  KR, 8'h40, 32'h0, 32'hF},
    {4'd0,  KW, 8'h40, 32'h0, 32'h0},
    {4'd6,  KC, 8'h00, 32'h0, 32'h1},
    {4'd0,  KW, 8'h11, 32'h00450011, 32'h0},
    {4'd0,  KW, 8'h21, 32'h1, 32'h0},
    {4'd7,  KI, 8'h00, 32'h002A, 32'h0},
    {4'd7,  KR, 8'h41, 32'h0, 32'h11},         // R7 tie lowest index
    {4'd8,  KC, 8'h00, 32'h0, 32'h0},          // R8 equal not nested
    {4'd0,  KW, 8'h17, 32'h00490077, 32'h0},
    {4'd0,  KW, 8'h27, 32'h1, 32'h0},
    {4'd8,  KI, 8'h00, 32'h00AA, 32'h0},
    {4'd8,  KC, 8'h00, 32'h0, 32'h1},          // R8 higher nests
    {4'd8,  KR, 8'h41, 32'h0, 32'h77},         // R7 highest wins
    {4'd8,  KC, 8'h00, 32'h0, 32'h0},
    {4'd9,  KW, 8'h42, 32'h0, 32'h0},
    {4'd9,  KC, 8'h00, 32'h0, 32'h0},
    {4'd9,  KR, 8'h17, 32'h0, 32'h00490077},   // R9 top retired
    {4'd9,  KR, 8'h11, 32'h0, 32'h40450011},   // R9 lower still in service
    {4'd9,  KW, 8'h42, 32'h0, 32'h0},
    {4'd9,  KC, 8'h00, 32'h0, 32'h1},
    {4'd7,  KR, 8'h41, 32'h0, 32'h33},
    {4'd0,  KW, 8'h42, 32'h0, 32'h0},
    {4'd9,  KC, 8'h00, 32'h0, 32'h0},
    {4'd0,  KW, 8'h13, 32'h80450033, 32'h0},
    {4'd2,  KR, 8'h13, 32'h0, 32'h80450033},   // R2 mask visible
    {4'd2,  KI, 8'h00, 32'h00A2, 32'h0},
    {4'd2,  KI, 8'h00, 32'h00AA, 32'h0},
    {4'd2,  KC, 8'h00, 32'h0, 32'h0},          // R2 masked not delivered
    {4'd0,  KW, 8'h13, 32'h00450033, 32'h0},
    {4'd2,  KC, 8'h00, 32'h0, 32'h1},          // R2 latched edge survives mask
    {4'd2,  KR, 8'h41, 32'h0, 32'h33},
    {4'd0,  KW, 8'h42, 32'h0, 32'h0},
    {4'd0,  KW, 8'h31, 32'h000A0061, 32'h0},
    {4'd0,  KW, 8'h45, 32'h2, 32'h0},
    {4'd12, KC, 8'h00, 32'h0, 32'h2},          // R12 to cpu1 only
    {4'd12, KR, 8'h31, 32'h0, 32'h400A0061},
    {4'd12, KR, 8'h49, 32'h0, 32'h61},
    {4'd12, KC, 8'h00, 32'h0, 32'h0},
    {4'd0,  KW, 8'h4A, 32'h0, 32'h0},
    {4'd12, KR, 8'h31, 32'h0, 32'h000A0061},
    {4'd0,  KW, 8'h4D, 32'h3, 32'h0},
    {4'd12, KC, 8'h00, 32'h0, 32'h3}           // R12 to both
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int req, input logic [1:0] kind, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] exp);
    @(negedge clk);
    we = 1'b0;
    re = 1'b0;
    case (kind)
      KW: begin we = 1'b1; addr = a; wdata = d; end
      KR: begin re = 1'b1; addr = a; #1; check(req, rdata, exp); end
      KI: irq = d[15:0];
      default: check(req, {30'b0, cpu_int}, exp);
    endcase
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(1, KC, 8'h00, 32'h0, 32'h0);
    step(1, KR, 8'h10, 32'h0, 32'h80400000);
    step(1, KR, 8'h31, 32'h0, 32'h80000000);
    step(1, KR, 8'h40, 32'h0, 32'h0);
    step(1, KR, 8'h41, 32'h0, 32'h0);
    for (int k = 0; k < NV; k++)
      step(int'(TBL[k][77:74]), TBL[k][73:72], TBL[k][71:64], TBL[k][63:32], TBL[k][31:0]);
    // R13 soft reset and pass-through flag
    step(0, KW, 8'h01, 32'h1, 32'h0);
    step(13, KC, 8'h00, 32'h0, 32'h0);
    step(13, KR, 8'h10, 32'h0, 32'h80400000);
    step(13, KR, 8'h31, 32'h0, 32'h80000000);
    step(13, KR, 8'h02, 32'h0, 32'h0);
    step(13, KR, 8'h40, 32'h0, 32'h0);
    step(13, KR, 8'h01, 32'h0, 32'h0);
    step(0, KW, 8'h01, 32'h2, 32'h0);
    step(13, KR, 8'h01, 32'h0, 32'h2);
    @(negedge clk);
    we = 1'b0;
    re = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule